// File: doc/BRIEF.md
# Dual-Acknowledge Strobe Transfer Controller

A bus master sends a burst over a shared 32-bit bus that carries both the address and the data. The first word is the address. The data words follow it, eight at most. The master marks each new word by flipping a single strobe line, so one word is announced per strobe edge of either polarity. Any number of listening slaves confirm each word on two shared acknowledge lines. Each acknowledge line is resolved as a wired-AND of the slave drivers: it reads high only when every slave has let it go, and it reads low while any slave still pulls it down.

The two acknowledge lines take turns. While a slave waits for a word it holds the "current" line low. When it has taken the word, it releases that line and, in the same step, pulls the other line low to be ready for the next word. The master moves on only when it sees a rising edge on the line it expects. That edge can only appear once the slowest slave has finished, so a slow slave can never cause a missed acknowledge or a stale one. Falling edges are never used.

The line parity continues from one transaction to the next. The block contains the master, one slave model per listener with a programmable response delay, and the wired-AND resolution of the acknowledge lines.

Top module: `hs3_xfer_sys`

## Requirements
- R1: After reset, strobe, bus, busy, done and every rx_valid are 0. ack_line is 2'b10: line 0 is held low by all slaves and line 1 is released.
- R2: A transaction accepted with command length L sends the word cmd_addr first. It then sends wr_data for wr_idx = 0, 1, …, L-1, in that order. Every slave reports exactly these words, in the same order, on its rx_valid / rx_word outputs.
- R3: strobe changes exactly once per word. The bus and strobe hold their values from one word until the next strobe change.
- R4: For each line j (bit j of ack_line), ack_line[j] is high only when bit j of every slave's 2-bit driver field is high. Slave s owns bits 2s+1..2s of slv_drv.
- R5: Across transactions, the overall word number n (counted from reset, starting at 0) is acknowledged on line n mod 2. The master advances only when that line is high while it was low one cycle earlier.
- R6: The master never advances while any slave still drives the expected line low. A falling edge, or activity on the other line, never advances it.
- R7: After it sees a strobe change, a slave waits slv_delay cycles. It then releases the line it held and pulls the other line low in the same cycle, and pulses rx_valid with the captured word.
- R8: The word period is 3 + D cycles, where D is the largest slave delay. done is a single-cycle pulse that follows the accepting clock edge by (L+1)·(3+D) cycles.
- R9: A cmd_len above 8 is treated as 8. A cmd_len of 0 sends the address word alone.
- R10: start is ignored while a transaction is in progress. No extra words are sent, and the command in flight is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a transaction (taken only when idle) |
| cmd_addr | input | 32 | Address word of the transaction |
| cmd_len | input | 4 | Number of data words (clamped to 8) |
| wr_data | input | 32 | Data word selected by wr_idx |
| wr_idx | output | 4 | Index of the next data word wanted |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when the last word is acknowledged |
| strobe | output | 1 | Word strobe, flips once per word |
| bus | output | 32 | Multiplexed address/data bus |
| ack_line | output | 2 | Resolved acknowledge lines (bit 0 = line 0) |
| slv_drv | output | 4 | Per-slave acknowledge drivers, 2 bits per slave, 1 = released |
| slv_delay | input | 8 | Per-slave response delay, 4 bits per slave |
| rx_valid | output | 2 | Per-slave pulse when a word is acknowledged |
| rx_word | output | 64 | Per-slave received word, 32 bits per slave |

## Verification
The assertions assume three things about the inputs. First, slv_delay does not change while a word is in flight. Second, wr_data presents the word for the current wr_idx in the same cycle. Third, start is sampled only once per request. The bench meets all three. It changes the delays and refills its data store only between transactions, and it drives wr_data combinationally from its own store indexed by wr_idx. It pulses start for one cycle at a time. The one exception is the deliberate mid-transaction pulse that exercises the ignore rule.

// File: rtl/hs3_pkg.sv
package hs3_pkg;

  typedef enum logic {
    M_IDLE,
    M_WAIT
  } mst_state_e;

  typedef enum logic {
    S_READY,
    S_HOLD
  } slv_state_e;

  // Driver pattern for a slave in phase ph: it holds line ph low
  // (0) and leaves the other line released (1). Bit 0 is line 0.
  function automatic logic [1:0] drv_for_phase(input logic ph);
    return ph ? 2'b01 : 2'b10;
  endfunction

  // Clamp a requested data length to the burst limit.
  function automatic int unsigned clamp_len(input int unsigned req,
                                            input int unsigned lim);
    return (req > lim) ? lim : req;
  endfunction

  // Rising edge seen on the selected line between two samples.
  function automatic logic rise_on(input logic [1:0] now_v,
                                   input logic [1:0] old_v,
                                   input logic       sel);
    return now_v[sel] & ~old_v[sel];
  endfunction

endpackage

// File: rtl/hs3_master.sv
module hs3_master
  import hs3_pkg::*;
#(
  parameter int DW      = 32,
  parameter int MAX_LEN = 8,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DW-1:0]    cmd_addr,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [DW-1:0]    wr_data,
  output logic [LEN_W-1:0] wr_idx,
  input  logic [1:0]       ack_line,
  output logic             busy,
  output logic             done,
  output logic             strobe,
  output logic [DW-1:0]    bus,
  output logic             adv_o,
  output logic             phase_o
);

  mst_state_e       state;
  logic             ph;
  logic [1:0]       ack_prev;
  logic [LEN_W-1:0] wcnt;
  logic [LEN_W-1:0] len_q;
  logic             strobe_q;
  logic [DW-1:0]    bus_q;
  logic             done_q;

  logic accept;
  logic adv;
  logic last_word;
  logic [LEN_W-1:0] len_eff;

  assign accept    = (state == M_IDLE) && start;
  assign adv       = (state == M_WAIT) && rise_on(ack_line, ack_prev, ph);
  assign last_word = (wcnt == len_q);
  assign len_eff   = LEN_W'(clamp_len(int'(cmd_len), MAX_LEN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= M_IDLE;
      ph       <= 1'b0;
      ack_prev <= 2'b10;
      wcnt     <= '0;
      len_q    <= '0;
      strobe_q <= 1'b0;
      bus_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      ack_prev <= ack_line;
      done_q   <= 1'b0;
      if (accept) begin
        len_q    <= len_eff;
        wcnt     <= '0;
        bus_q    <= cmd_addr;
        strobe_q <= ~strobe_q;
        state    <= M_WAIT;
      end else if (adv) begin
        ph <= ~ph;
        if (last_word) begin
          state  <= M_IDLE;
          done_q <= 1'b1;
        end else begin
          bus_q    <= wr_data;
          strobe_q <= ~strobe_q;
          wcnt     <= wcnt + 1'b1;
        end
      end
    end
  end

  assign wr_idx  = wcnt;
  assign busy    = (state == M_WAIT);
  assign done    = done_q;
  assign strobe  = strobe_q;
  assign bus     = bus_q;
  assign adv_o   = adv;
  assign phase_o = ph;

  // R3
  hold_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == M_WAIT && !adv) |=> ($stable(bus_q) && $stable(strobe_q)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == M_WAIT) |-> (wcnt <= len_q && len_q <= MAX_LEN));

  // R10
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == M_WAIT && start && !adv) |=> ($stable(len_q) && $stable(bus_q)));

endmodule

// File: rtl/hs3_slave.sv
module hs3_slave
  import hs3_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [DW-1:0]    bus,
  input  logic [DLY_W-1:0] delay,
  output logic [1:0]       drv,
  output logic             pend,
  output logic             rx_valid,
  output logic [DW-1:0]    rx_word
);

  slv_state_e       st;
  logic             ph;
  logic             seen;
  logic [DLY_W-1:0] cnt;
  logic [DW-1:0]    word_q;
  logic             rxv_q;

  logic detect;
  logic flip;

  assign detect = (st == S_READY) && (strobe != seen);
  assign flip   = (st == S_HOLD) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_READY;
      ph     <= 1'b0;
      seen   <= 1'b0;
      cnt    <= '0;
      word_q <= '0;
      rxv_q  <= 1'b0;
    end else begin
      rxv_q <= 1'b0;
      if (detect) begin
        seen   <= strobe;
        word_q <= bus;
        cnt    <= delay;
        st     <= S_HOLD;
      end else if (flip) begin
        ph    <= ~ph;
        rxv_q <= 1'b1;
        st    <= S_READY;
      end else if (st == S_HOLD) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign drv      = drv_for_phase(ph);
  assign pend     = (st == S_HOLD);
  assign rx_valid = rxv_q;
  assign rx_word  = word_q;

  // R7
  swap_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flip |=> (drv == ~$past(drv) && rx_valid));

  // R7
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !flip) |=> ($stable(drv) && !rx_valid));

endmodule

// File: rtl/hs3_ack_resolve.sv
module hs3_ack_resolve #(
  parameter int NUM_SLV = 2
) (
  input  logic [NUM_SLV*2-1:0] drv,
  output logic [1:0]           line
);

  for (genvar j = 0; j < 2; j++) begin : g_line
    logic [NUM_SLV-1:0] col;
    for (genvar s = 0; s < NUM_SLV; s++) begin : g_col
      assign col[s] = drv[2*s + j];
    end
    assign line[j] = &col;
  end

endmodule

// File: rtl/hs3_xfer_sys.sv
module hs3_xfer_sys
  import hs3_pkg::*;
#(
  parameter int DW      = 32,
  parameter int MAX_LEN = 8,
  parameter int NUM_SLV = 2,
  parameter int DLY_W   = 4,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [DW-1:0]            cmd_addr,
  input  logic [LEN_W-1:0]         cmd_len,
  input  logic [DW-1:0]            wr_data,
  output logic [LEN_W-1:0]         wr_idx,
  output logic                     busy,
  output logic                     done,
  output logic                     strobe,
  output logic [DW-1:0]            bus,
  output logic [1:0]               ack_line,
  output logic [NUM_SLV*2-1:0]     slv_drv,
  input  logic [NUM_SLV*DLY_W-1:0] slv_delay,
  output logic [NUM_SLV-1:0]       rx_valid,
  output logic [NUM_SLV*DW-1:0]    rx_word
);

  logic               m_adv;
  logic               m_phase;
  logic [NUM_SLV-1:0] slv_pend;

  hs3_master #(.DW(DW), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_master (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cmd_addr (cmd_addr),
    .cmd_len  (cmd_len),
    .wr_data  (wr_data),
    .wr_idx   (wr_idx),
    .ack_line (ack_line),
    .busy     (busy),
    .done     (done),
    .strobe   (strobe),
    .bus      (bus),
    .adv_o    (m_adv),
    .phase_o  (m_phase)
  );

  for (genvar s = 0; s < NUM_SLV; s++) begin : g_slv
    hs3_slave #(.DW(DW), .DLY_W(DLY_W)) u_slave (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe   (strobe),
      .bus      (bus),
      .delay    (slv_delay[s*DLY_W +: DLY_W]),
      .drv      (slv_drv[2*s +: 2]),
      .pend     (slv_pend[s]),
      .rx_valid (rx_valid[s]),
      .rx_word  (rx_word[s*DW +: DW])
    );
  end

  hs3_ack_resolve #(.NUM_SLV(NUM_SLV)) u_resolve (
    .drv  (slv_drv),
    .line (ack_line)
  );

  // R6
  adv_all_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_adv |-> (slv_pend == '0));

  // R4
  pend_holds_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_pend != '0) |-> !ack_line[m_phase]);

  // R5
  phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_adv |=> (m_phase != $past(m_phase)));

endmodule

// File: tb/hs3_xfer_sys_tb.sv
module hs3_xfer_sys_tb_top;

  localparam int DW = 32;
  localparam int NS = 2;
  localparam int DLW = 4;
  localparam int LW = 4;
  localparam int MAXL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [DW-1:0] cmd_addr = '0;
  logic [LW-1:0] cmd_len = '0;
  logic [DW-1:0] wr_data;
  logic [LW-1:0] wr_idx;
  logic busy, done, strobe;
  logic [DW-1:0] bus;
  logic [1:0] ack_line;
  logic [NS*2-1:0] slv_drv;
  logic [NS*DLW-1:0] slv_delay = '0;
  logic [NS-1:0] rx_valid;
  logic [NS*DW-1:0] rx_word;

  logic [DW-1:0] dmem [0:15];
  assign wr_data = dmem[wr_idx];

  always #5 clk = ~clk;

  hs3_xfer_sys dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .wr_data(wr_data), .wr_idx(wr_idx), .busy(busy),
    .done(done), .strobe(strobe), .bus(bus), .ack_line(ack_line),
    .slv_drv(slv_drv), .slv_delay(slv_delay), .rx_valid(rx_valid),
    .rx_word(rx_word)
  );

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] expq [NS][$];
  logic mon_on = 1'b0;
  logic bp = 1'b0;
  logic sp [NS];
  logic p_strobe, p_busy;
  logic [DW-1:0] p_bus;
  logic [NS*2-1:0] p_drv;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-cycle reference monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (mon_on) begin
      for (int j = 0; j < 2; j++) begin
        logic all_hi;
        all_hi = 1'b1;
        for (int s = 0; s < NS; s++) all_hi &= slv_drv[2*s+j];
        chk(ack_line[j] == all_hi, "R4 wired-and line", ack_line[j], all_hi);
      end
      if (strobe == p_strobe)
        chk(bus == p_bus, "R3 bus stable between strobes", bus, p_bus);
      if ((strobe != p_strobe && p_busy) || (done && p_busy)) begin
        logic all_rel;
        all_rel = 1'b1;
        for (int s = 0; s < NS; s++) all_rel &= p_drv[2*s+bp];
        chk(all_rel, "R6 advance only after all released", all_rel, 1);
        chk(ack_line[bp] == 1'b1, "R5 advance on expected line", ack_line[bp], 1);
        bp = ~bp;
      end
      for (int s = 0; s < NS; s++) begin
        if (rx_valid[s]) begin
          logic [DW-1:0] e;
          logic [DW-1:0] a;
          a = rx_word[s*DW +: DW];
          if (expq[s].size() == 0) begin
            chk(1'b0, "R2 unexpected word", a, 0);
          end else begin
            e = expq[s].pop_front();
            chk(a == e, "R2 word order", a, e);
          end
          sp[s] = ~sp[s];
          chk(slv_drv[2*s +: 2] == (sp[s] ? 2'b01 : 2'b10), "R7 line swap",
              slv_drv[2*s +: 2], sp[s] ? 2'b01 : 2'b10);
        end
      end
    end
    p_strobe = strobe;
    p_busy   = busy;
    p_bus    = bus;
    p_drv    = slv_drv;
  end

  task automatic run_xfer(input int tno, input logic [LW-1:0] len,
                          input int d0, input int d1, input bit poke);
    int eff, dmax, n;
    logic [DW-1:0] addr;
    @(negedge clk);
    eff  = (len > MAXL) ? MAXL : int'(len);
    dmax = (d0 > d1) ? d0 : d1;
    addr = 32'h1000_0000 + 32'(tno) * 32'h0001_0100;
    for (int i = 0; i < 16; i++) dmem[i] = 32'hC0DE_0000 ^ (32'(tno) << 20) ^ (32'(i) * 32'h0101_0011);
    slv_delay = {DLW'(d1), DLW'(d0)};
    for (int s = 0; s < NS; s++) begin
      expq[s].push_back(addr);
      for (int i = 0; i < eff; i++) expq[s].push_back(dmem[i]);
    end
    cmd_addr = addr;
    cmd_len  = len;
    start    = 1'b1;
    @(posedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      start = 1'b0;
      if (poke && n == 4) begin
        start = 1'b1;
        cmd_addr = 32'hDEAD_BEEF;
        cmd_len = 4'd2;
      end
    end while (!done && n < 2000);
    start = 1'b0;
    chk(n == (eff + 1) * (3 + dmax) + 1, "R8 transaction latency", n, (eff + 1) * (3 + dmax) + 1);
    repeat (12) @(negedge clk);
    chk(busy == 1'b0, "R10 no extra transaction", busy, 0);
    for (int s = 0; s < NS; s++)
      chk(expq[s].size() == 0, "R2 all words delivered", expq[s].size(), 0);
  endtask

  initial begin
    for (int s = 0; s < NS; s++) sp[s] = 1'b0;
    for (int i = 0; i < 16; i++) dmem[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(strobe == 0 && busy == 0 && done == 0, "R1 reset outputs", {strobe, busy, done}, 0);
    chk(bus == 0 && rx_valid == 0, "R1 reset bus", bus, 0);
    chk(ack_line == 2'b10, "R1 reset ack lines", ack_line, 2'b10);
    mon_on = 1'b1;
    run_xfer(1, 4'd8, 0, 5, 1'b0);   // R2 fast and slow slave
    run_xfer(2, 4'd3, 7, 0, 1'b0);   // R5 parity carries across transactions
    run_xfer(3, 4'd0, 1, 1, 1'b0);   // R9 address only
    run_xfer(4, 4'd12, 2, 3, 1'b0);  // R9 clamp to 8
    run_xfer(5, 4'd5, 4, 0, 1'b1);   // R10 start while busy
    run_xfer(6, 4'd1, 0, 0, 1'b0);   // R8 minimum period
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule